// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a management-bus master for Ethernet PHYs. Software controls it through one 32-bit command word. To start a transaction, software writes a word with both the start/busy flag and the enable flag set. The same write supplies the operation type, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data. The engine then sends one standard Clause 22 management frame on MDC/MDIO and clears the busy flag when the frame is over.

Software detects completion by polling the busy flag. After a read, the low 16 bits of the same word hold the value returned by the PHY. The other fields keep the values of the command that was issued.

MDC is the system clock divided by 2×`DIV_HALF`. The default of 20 gives 5 MHz from a 200 MHz clock, and one frame then lasts 12.8 µs. This keeps a transaction well inside the 20 µs that polling software allows.

The data line is split into output, output-enable and input. A tri-state pad outside the block combines them.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads 0, MDC is low and MDIO is released (output enable 0).
- R2: A write whose bit 31 (busy) and bit 30 (enable) are both 1, accepted while idle, starts a frame. Bit 31 reads back 1 from the next clock onward.
- R3: An accepted write with bit 30 clear stores the fields but starts no frame. Bit 31 reads 0 and MDC stays low.
- R4: A write frame (bit 27 = 0) sends these fields, all MSB first: 32 ones, start 01, opcode 01, PHY address (bits 25:21), register address (bits 20:16), turnaround 10, and data (bits 15:0).
- R5: A read frame (bit 27 = 1) sends opcode 10. MDIO is released for the two turnaround bits and the 16 data bits. The data bits are sampled on the rising edges of MDC and placed in bits 15:0. Bits 30, 27 and 25:16 are kept.
- R6: While running, MDC has a period of 2×DIV_HALF clock cycles and is held low when idle. MDIO and its enable change only while MDC is low.
- R7: Bit 31 returns to 0 exactly 128×DIV_HALF+1 cycles after the clock edge that accepted the starting write. This is 64 MDC periods.
- R8: Any write while bit 31 reads 1 is ignored: the word is unchanged and no second frame is sent.
- R9: Bits 29, 28 and 26 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word value to write |
| cmd_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_in | input | 1 | MDIO value seen at the pad |

## Verification
A wrong bit counter or shift state shows up within one frame as a misplaced field in the serial stream. It can also show up as a busy flag that clears at a cycle other than 128×DIV_HALF+1. A wrong direction flag shows up as MDIO being driven during a read turnaround. A broken capture path shows up in bits 15:0 the cycle after busy drops. A lost busy state lets an ignored write start a second frame, and the scoreboard then sees a frame nobody queued.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int BUSY_POS   = 31;
  localparam int EN_POS     = 30;
  localparam int RD_POS     = 27;
  localparam int PHY_LSB    = 21;
  localparam int REG_LSB    = 16;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic rd, input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad, input logic [DATA_W-1:0] wdat);
    logic [1:0] op;
    logic [1:0] ta;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regad, ta, (rd ? {DATA_W{1'b1}} : wdat)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap      = en && (cnt_q == LAST);
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: clock parks low whenever no frame is running
  p_mdc_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq import mdio_cmd_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] start_phy,
  input  logic [ADDR_W-1:0] start_reg,
  input  logic [DATA_W-1:0] start_data,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rd_value,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic                  active_q, done_q, rd_q, oe_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [DATA_W-1:0]     cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      rd_q     <= 1'b0;
      oe_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      cap_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        rd_q     <= start_rd;
        oe_q     <= 1'b1;
        sh_q     <= build_frame(start_rd, start_phy, start_reg, start_data);
      end else if (active_q) begin
        if (rise_tick && rd_q && (int'(idx_q) >= DATA_FIRST))
          cap_q <= {cap_q[DATA_W-2:0], mdio_i};
        if (fall_tick) begin
          if (idx_q == LAST_IDX) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
            oe_q     <= 1'b0;
          end else begin
            idx_q <= idx_q + 1'b1;
            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
            oe_q  <= !(rd_q && (int'(idx_q) + 1 >= TA_FIRST));
          end
        end
      end
    end
  end

  assign active   = active_q;
  assign done     = done_q;
  assign rd_value = cap_q;
  assign mdio_o   = sh_q[FRAME_BITS-1];
  assign mdio_oe  = oe_q;

  // R5: line released from turnaround to the end of a read
  p_read_released_r5: assert property (@(posedge clk) disable iff (rst)
    (active_q && rd_q && int'(idx_q) >= TA_FIRST) |-> !oe_q);
  // R7: a frame ends only after its last bit
  p_frame_length_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(idx_q) == LAST_IDX);
  // R8: a new frame is never loaded over a running one
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    start |-> !active_q);
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg import mdio_cmd_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_value,
  output logic [WORD_W-1:0] word,
  output logic              start,
  output logic              start_rd,
  output logic [ADDR_W-1:0] start_phy,
  output logic [ADDR_W-1:0] start_reg,
  output logic [DATA_W-1:0] start_data
);
  logic              busy_q, en_q, rd_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              unused_bits;

  assign unused_bits = ^{wr_data[29:28], wr_data[26]};
  assign accept      = wr_en && !busy_q;
  assign start       = accept && wr_data[BUSY_POS] && wr_data[EN_POS];
  assign start_rd    = wr_data[RD_POS];
  assign start_phy   = wr_data[PHY_LSB +: ADDR_W];
  assign start_reg   = wr_data[REG_LSB +: ADDR_W];
  assign start_data  = wr_data[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      en_q   <= 1'b0;
      rd_q   <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
      if (rd_q) data_q <= rd_value;
    end else if (accept) begin
      busy_q <= wr_data[BUSY_POS] && wr_data[EN_POS];
      en_q   <= wr_data[EN_POS];
      rd_q   <= start_rd;
      phy_q  <= start_phy;
      reg_q  <= start_reg;
      data_q <= start_data;
    end
  end

  assign word = {busy_q, en_q, 2'b00, rd_q, 1'b0, phy_q, reg_q, data_q};

  // R8: fields frozen while a command is outstanding
  p_busy_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> (busy_q && $stable(phy_q) && $stable(reg_q) &&
                           $stable(rd_q) && $stable(data_q)));
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master import mdio_cmd_pkg::*; #(
  parameter int DIV_HALF = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic [WORD_W-1:0] cmd_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  logic              start, start_rd, active, done, rise_tick, fall_tick;
  logic [ADDR_W-1:0] start_phy, start_reg;
  logic [DATA_W-1:0] start_data, rd_value;

  mdio_cmd_reg i_reg (
    .clk(clk), .rst(rst), .wr_en(cmd_wr), .wr_data(cmd_wdata),
    .done(done), .rd_value(rd_value), .word(cmd_rdata),
    .start(start), .start_rd(start_rd), .start_phy(start_phy),
    .start_reg(start_reg), .start_data(start_data));

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) i_div (
    .clk(clk), .rst(rst), .en(active), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick));

  mdio_frame_seq i_seq (
    .clk(clk), .rst(rst), .start(start), .start_rd(start_rd),
    .start_phy(start_phy), .start_reg(start_reg), .start_data(start_data),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_in),
    .active(active), .done(done), .rd_value(rd_value),
    .mdio_o(mdio_out), .mdio_oe(mdio_oe));

  // R6: data and direction hold while the management clock is high
  p_mdio_quiet_high_r6: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_out) && $stable(mdio_oe)));
  // R2: busy reads set whenever the clock is running
  p_busy_while_clocking_r2: assert property (@(posedge clk) disable iff (rst)
    mdc |-> cmd_rdata[BUSY_POS]);
endmodule

// File: tb/test_mdio_cmd_master.sv
module test_mdio_cmd_master;
  localparam int DH = 20;
  localparam int FB = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic mdc, mdio_out, mdio_oe;
  logic mdio_in = 1'b1;

  always #2.5 clk = ~clk;

  mdio_cmd_master #(.DIV_HALF(DH)) i_mdio_cmd_master (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in));

  typedef struct { logic [63:0] frame; logic rd; logic [15:0] reply; } item_t;
  item_t exp_q[$];

  int checks = 0;
  int errors = 0;
  int bench_idx = 0;
  int frames_seen = 0;
  int cyc = 0;
  int mdc_period = 0;
  logic cur_rd = 1'b0;
  logic [15:0] cur_reply = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  // PHY model: drives read data after MDC falls
  always @(negedge mdc) begin
    if (cur_rd && bench_idx >= 48 && bench_idx < 64)
      mdio_in <= cur_reply[15 - (bench_idx - 48)];
    else
      mdio_in <= 1'b1;
  end

  // Monitor: collects each frame and compares with the scoreboard
  initial begin
    forever begin
      logic [63:0] got;
      logic [63:0] mask;
      bit oe_ok;
      int t0;
      item_t it;
      got = '0;
      oe_ok = 1'b1;
      t0 = 0;
      for (int i = 0; i < FB; i++) begin
        @(posedge mdc);
        #1;
        if (i == 0) begin
          t0 = cyc;
          if (exp_q.size() > 0) begin
            cur_rd = exp_q[0].rd;
            cur_reply = exp_q[0].reply;
          end else begin
            cur_rd = 1'b0;
          end
        end
        if (i == 1) mdc_period = cyc - t0;
        got[63 - i] = mdio_out;
        if (mdio_oe !== !(cur_rd && i >= 46)) oe_ok = 1'b0;
        bench_idx = i + 1;
      end
      bench_idx = 0;
      frames_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected frame", got, 64'h0);
      end else begin
        it = exp_q.pop_front();
        mask = it.rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        chk((got & mask) == (it.frame & mask), it.rd ? "R5 read frame bits" : "R4 write frame bits",
            got & mask, it.frame & mask);
        chk(oe_ok, "R5 drive direction per bit", {63'h0, oe_ok}, 64'h1);
      end
      cur_rd = 1'b0;
    end
  end

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (cmd_rdata[31] && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [31:0] word_of(input logic b, input logic e, input logic rd,
                                          input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {b, e, 2'b00, rd, 1'b0, p, r, d};
  endfunction

  task automatic run_cmd(input logic rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input logic [15:0] reply);
    item_t it;
    int n;
    logic [31:0] w;
    it.frame = exp_frame(rd, p, r, d);
    it.rd = rd;
    it.reply = reply;
    exp_q.push_back(it);
    w = word_of(1'b1, 1'b1, rd, p, r, d) | 32'h3400_0000;
    wr(w);
    chk(cmd_rdata[31] == 1'b1, "R2 busy after start", cmd_rdata[31], 1);
    chk(cmd_rdata[29:28] == 2'b00 && cmd_rdata[26] == 1'b0, "R9 reserved bits zero",
        {cmd_rdata[29:28], cmd_rdata[26]}, 0);
    wait_idle(n);
    chk(n == 128 * DH + 1, "R7 busy duration", n, 128 * DH + 1);
    if (rd)
      chk(cmd_rdata == word_of(1'b0, 1'b1, 1'b1, p, r, reply), "R5 read result in word",
          cmd_rdata, word_of(1'b0, 1'b1, 1'b1, p, r, reply));
    else
      chk(cmd_rdata == word_of(1'b0, 1'b1, 1'b0, p, r, d), "R4 word after write",
          cmd_rdata, word_of(1'b0, 1'b1, 1'b0, p, r, d));
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit mdc_seen;
    item_t a;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_rdata == 32'h0, "R1 word after reset", cmd_rdata, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc low and line released", {mdc, mdio_oe}, 0);

    run_cmd(1'b0, 5'h11, 5'h0A, 16'hA5C3, 16'h0);
    chk(mdc_period == 2 * DH, "R6 mdc period", mdc_period, 2 * DH);
    run_cmd(1'b1, 5'h1F, 5'h00, 16'h0, 16'h3C5A);
    run_cmd(1'b1, 5'h02, 5'h11, 16'h0, 16'h8001);
    run_cmd(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0);
    run_cmd(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0);

    // R8 write while busy is ignored
    a.frame = exp_frame(1'b0, 5'h02, 5'h03, 16'h1234);
    a.rd = 1'b0;
    a.reply = '0;
    exp_q.push_back(a);
    wr(word_of(1'b1, 1'b1, 1'b0, 5'h02, 5'h03, 16'h1234));
    repeat (100) @(negedge clk);
    wr(word_of(1'b1, 1'b1, 1'b1, 5'h15, 5'h0C, 16'h0F0F));
    chk(cmd_rdata == word_of(1'b1, 1'b1, 1'b0, 5'h02, 5'h03, 16'h1234), "R8 word unchanged",
        cmd_rdata, word_of(1'b1, 1'b1, 1'b0, 5'h02, 5'h03, 16'h1234));
    wait_idle(n);
    repeat (4 * DH) @(negedge clk);
    chk(cmd_rdata == word_of(1'b0, 1'b1, 1'b0, 5'h02, 5'h03, 16'h1234), "R8 original command kept",
        cmd_rdata, word_of(1'b0, 1'b1, 1'b0, 5'h02, 5'h03, 16'h1234));
    chk(frames_seen == 6, "R8 single frame sent", frames_seen, 6);

    // R3 enable clear: fields stored, no frame
    wr(word_of(1'b1, 1'b0, 1'b0, 5'h07, 5'h02, 16'hBEEF));
    chk(cmd_rdata == word_of(1'b0, 1'b0, 1'b0, 5'h07, 5'h02, 16'hBEEF), "R3 stored without busy",
        cmd_rdata, word_of(1'b0, 1'b0, 1'b0, 5'h07, 5'h02, 16'hBEEF));
    mdc_seen = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (mdc) mdc_seen = 1'b1;
    end
    chk(!mdc_seen && frames_seen == 6, "R3 no clock activity", {mdc_seen, 8'(frames_seen)}, 6);

    run_cmd(1'b1, 5'h0B, 5'h1E, 16'h0, 16'h0000);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule